// File: doc/BRIEF.md
# SPI Flash Command Engine

This block is a register-controlled SPI master that performs one complete flash command each time software starts it. The transaction opens with an opcode byte taken from a dedicated register. A programmed number of payload bytes follows, fetched from a small shared byte buffer. The engine then clocks in a programmed number of response bytes and writes them into that same buffer, immediately after the payload bytes.

Software reaches the block over a simple byte-wide register bus. Through it, software loads the opcode, programs one register that packs both byte counts, and fills the buffer through a data port whose pointer advances on every access. It then sets the start bit and polls the busy flag. Once the command finishes, software rewinds the pointer and reads the payload and response back through the same port.

An optional drop mode reproduces a known quirk of some controllers. When the payload count is zero, the last response byte is discarded instead of stored. The block drives the chip select, clock and data pins of a single SPI device in mode 0.

Top module: `spi_cmd_engine`

## Requirements
- R1: The opcode register (offset 0x0) is shifted out first after chip select falls, MSB first, in SPI mode 0: SCK idles low, MOSI changes only while SCK is low, and MISO is sampled on the rising edge. The opcode never passes through the buffer. MOSI is 0 during response bytes.
- R2: The count register (offset 0x1) holds the number of response bytes in bits 7:4 and the number of payload bytes in bits 3:0. It reads back unchanged during and after a transaction.
- R3: Writing 1 to bit 0 of the control register (offset 0x2) starts a transaction. Bit 0 reads 1 while the transaction runs and returns to 0 on its own when the transaction ends.
- R4: Each read or write of the data port (offset 0xC) accesses the buffer entry at the pointer and then advances the pointer by one. The pointer reads back in bits 2:0 of offset 0xD and wraps modulo 8.
- R5: Payload bytes are sent from the buffer starting at the pointer. Response bytes are stored in the entries that follow them. At completion the pointer equals (payload + stored response) modulo 8.
- R6: Bit 2 of the control register is a persistent drop-mode enable. While it is set and the payload count is zero, the final response byte is shifted in but not stored, and the pointer does not advance for it. With a nonzero payload count, all response bytes are stored.
- R7: Writing 1 to bit 1 of the control register resets the pointer to 0. This bit always reads 0.
- R8: Chip select stays low from the first opcode bit to the last response bit. It then stays high for at least SCK_DIV system clocks before any further transaction begins.
- R9: While busy, writes to the opcode, count, control and data-port registers have no effect, and data-port reads return 0 without moving the pointer.
- R10: After reset, the opcode, count, control and pointer registers read 0, chip select is high and SCK is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 4 | Register offset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rd | input | 1 | Register read strobe |
| reg_rdata | output | 8 | Read data, valid the cycle after reg_rd |
| spi_sck | output | 1 | SPI clock |
| spi_mosi | output | 1 | Serial data to the device |
| spi_miso | input | 1 | Serial data from the device |
| spi_cs_n | output | 1 | Active-low device select |

## Verification
A device model answers every byte position with a distinct value and records everything it receives. This lets one run expose misplaced, reordered or missing bytes on both directions of the link. The command table covers the following cases:
- opcode-only commands;
- commands that only send payload;
- commands that only receive;
- mixed commands, including one that fills all eight entries so that the final pointer wraps to zero;
- drop mode with and without payload, which separates a correctly gated discard from an unconditional one.

Directed tests write nine bytes to show pointer wrap and overwrite, exercise the pointer-reset bit, and issue register traffic in the middle of a command to show that it is ignored.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;
  localparam logic [3:0] OFS_OPC = 4'h0;
  localparam logic [3:0] OFS_CNT = 4'h1;
  localparam logic [3:0] OFS_CTL = 4'h2;
  localparam logic [3:0] OFS_DAT = 4'hC;
  localparam logic [3:0] OFS_PTR = 4'hD;

  typedef enum logic [2:0] {
    S_IDLE,
    S_OPC,
    S_TX,
    S_RX,
    S_GAP
  } seq_t;
endpackage

// File: rtl/spi_eng_fifo.sv
module spi_eng_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  assign rdata = mem[addr];
endmodule

// File: rtl/spi_eng_shift.sv
module spi_eng_shift #(
  parameter int SCK_DIV = 4,
  localparam int HALF   = SCK_DIV / 2,
  localparam int CW     = $clog2(HALF + 1)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       load,
  input  logic [7:0] load_byte,
  input  logic       miso,
  output logic       sck,
  output logic       mosi,
  output logic [7:0] rx_byte,
  output logic       done
);
  logic [7:0]    txsh, rxsh;
  logic [2:0]    bitc;
  logic [CW-1:0] divc;
  logic          active;

  always_ff @(posedge clk) begin
    if (rst) begin
      txsh <= '0; rxsh <= '0; bitc <= '0; divc <= '0;
      active <= 1'b0; sck <= 1'b0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (load) begin
        active <= 1'b1;
        txsh   <= load_byte;
        bitc   <= '0;
        divc   <= '0;
        sck    <= 1'b0;
      end else if (active) begin
        if (divc == CW'(HALF - 1)) begin
          divc <= '0;
          if (!sck) begin
            sck  <= 1'b1;
            rxsh <= {rxsh[6:0], miso};
          end else begin
            sck <= 1'b0;
            if (bitc == 3'd7) begin
              active <= 1'b0;
              done   <= 1'b1;
            end else begin
              bitc <= bitc + 3'd1;
              txsh <= {txsh[6:0], 1'b0};
            end
          end
        end else begin
          divc <= divc + CW'(1);
        end
      end
    end
  end

  assign mosi    = txsh[7];
  assign rx_byte = rxsh;
endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
  import spi_eng_pkg::*;
#(
  parameter int SCK_DIV = 4,
  parameter int DEPTH   = 8,
  localparam int AW     = $clog2(DEPTH),
  localparam int GW     = $clog2(SCK_DIV + 1)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [3:0] reg_addr,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  input  logic       reg_rd,
  output logic [7:0] reg_rdata,
  output logic       spi_sck,
  output logic       spi_mosi,
  input  logic       spi_miso,
  output logic       spi_cs_n
);
  logic [7:0]    opc_q, cnt_q, rdata_q, sh_byte_q;
  logic          drop_q, busy_q, cs_n_q, sh_load_q;
  logic [AW-1:0] ptr_q;
  logic [3:0]    tx_left, rx_left;
  logic [GW-1:0] gap_c;
  seq_t          st;

  logic [7:0] fifo_rd, fifo_wd, sh_rx;
  logic       fifo_we, sh_done, drop_last;

  assign drop_last = drop_q && (cnt_q[3:0] == 4'd0) && (rx_left == 4'd0);

  always_comb begin
    if (busy_q) begin
      fifo_we = (st == S_RX) && sh_done && !drop_last;
      fifo_wd = sh_rx;
    end else begin
      fifo_we = reg_wr && (reg_addr == OFS_DAT);
      fifo_wd = reg_wdata;
    end
  end

  spi_eng_fifo #(.DEPTH(DEPTH), .W(8)) u_fifo (
    .clk(clk), .we(fifo_we), .addr(ptr_q), .wdata(fifo_wd), .rdata(fifo_rd)
  );

  spi_eng_shift #(.SCK_DIV(SCK_DIV)) u_shift (
    .clk(clk), .rst(rst), .load(sh_load_q), .load_byte(sh_byte_q),
    .miso(spi_miso), .sck(spi_sck), .mosi(spi_mosi),
    .rx_byte(sh_rx), .done(sh_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      opc_q <= '0; cnt_q <= '0; drop_q <= 1'b0; busy_q <= 1'b0;
      ptr_q <= '0; tx_left <= '0; rx_left <= '0; gap_c <= '0;
      cs_n_q <= 1'b1; sh_load_q <= 1'b0; sh_byte_q <= '0; st <= S_IDLE;
    end else begin
      sh_load_q <= 1'b0;
      if (!busy_q) begin
        if (reg_wr) begin
          case (reg_addr)
            OFS_OPC: opc_q <= reg_wdata;
            OFS_CNT: cnt_q <= reg_wdata;
            OFS_DAT: ptr_q <= ptr_q + AW'(1);
            OFS_CTL: begin
              drop_q <= reg_wdata[2];
              if (reg_wdata[1]) ptr_q <= '0;
              if (reg_wdata[0]) begin
                busy_q    <= 1'b1;
                cs_n_q    <= 1'b0;
                sh_load_q <= 1'b1;
                sh_byte_q <= opc_q;
                tx_left   <= cnt_q[3:0];
                rx_left   <= cnt_q[7:4];
                st        <= S_OPC;
              end
            end
            default: ;
          endcase
        end else if (reg_rd && reg_addr == OFS_DAT) begin
          ptr_q <= ptr_q + AW'(1);
        end
      end else begin
        case (st)
          S_OPC, S_TX, S_RX: begin
            if (sh_done) begin
              if (st == S_RX && !drop_last) ptr_q <= ptr_q + AW'(1);
              if (st != S_RX && tx_left != 4'd0) begin
                sh_load_q <= 1'b1;
                sh_byte_q <= fifo_rd;
                ptr_q     <= ptr_q + AW'(1);
                tx_left   <= tx_left - 4'd1;
                st        <= S_TX;
              end else if (rx_left != 4'd0) begin
                sh_load_q <= 1'b1;
                sh_byte_q <= 8'h00;
                rx_left   <= rx_left - 4'd1;
                st        <= S_RX;
              end else begin
                cs_n_q <= 1'b1;
                gap_c  <= '0;
                st     <= S_GAP;
              end
            end
          end
          S_GAP: begin
            gap_c <= gap_c + GW'(1);
            if (gap_c == GW'(SCK_DIV - 1)) begin
              busy_q <= 1'b0;
              st     <= S_IDLE;
            end
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (reg_rd) begin
      case (reg_addr)
        OFS_OPC: rdata_q <= opc_q;
        OFS_CNT: rdata_q <= cnt_q;
        OFS_CTL: rdata_q <= {5'b0, drop_q, 1'b0, busy_q};
        OFS_DAT: rdata_q <= busy_q ? 8'h00 : fifo_rd;
        OFS_PTR: rdata_q <= {{(8-AW){1'b0}}, ptr_q};
        default: rdata_q <= 8'h00;
      endcase
    end
  end

  assign reg_rdata = rdata_q;
  assign spi_cs_n  = cs_n_q;
endmodule

// File: rtl/spi_cmd_engine_chk.sv
module spi_cmd_engine_chk #(
  parameter int PW = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          busy,
  input logic          cs_n,
  input logic          sck,
  input logic          mosi,
  input logic          reg_wr,
  input logic          reg_rd,
  input logic [7:0]    cnt,
  input logic [PW-1:0] ptr
);
  // R8
  cs_low_only_busy_chk: assert property (@(posedge clk) disable iff (rst)
    !cs_n |-> busy);

  // R1
  sck_idle_when_deselected_chk: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> !sck);

  // R1
  mosi_hold_while_sck_high_chk: assert property (@(posedge clk) disable iff (rst)
    (sck && $past(sck)) |-> $stable(mosi));

  // R2
  counts_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(cnt));

  // R4
  ptr_quiet_when_untouched_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && !reg_wr && !reg_rd) |=> $stable(ptr));

  // R3
  busy_ends_deselected_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> cs_n);
endmodule

bind spi_cmd_engine spi_cmd_engine_chk #(.PW(AW)) u_chk (
  .clk(clk), .rst(rst), .busy(busy_q), .cs_n(spi_cs_n), .sck(spi_sck),
  .mosi(spi_mosi), .reg_wr(reg_wr), .reg_rd(reg_rd), .cnt(cnt_q), .ptr(ptr_q)
);

// File: tb/tb_spi_cmd_engine.sv
`timescale 1ns/1ps
module tb_spi_cmd_engine;
  localparam int SCK_DIV = 4;
  localparam logic [3:0] A_OPC = 4'h0, A_CNT = 4'h1, A_CTL = 4'h2,
                         A_DAT = 4'hC, A_PTR = 4'hD;

  logic clk = 1'b0, rst = 1'b1;
  logic [3:0] reg_addr = '0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic spi_sck, spi_mosi, spi_cs_n;
  logic spi_miso = 1'b0;

  int nchk = 0, nfail = 0;

  always #10 clk = ~clk;

  spi_cmd_engine #(.SCK_DIV(SCK_DIV)) dut (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
    .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
    .spi_cs_n(spi_cs_n)
  );

  // device model: answer byte k with resp(k), record what it receives
  function automatic logic [7:0] resp(int k);
    return 8'h5A ^ 8'(k * 19);
  endfunction

  logic [7:0] seen [16];
  int   sbit = 0;
  logic sck_prev = 1'b0;
  always @(spi_cs_n or spi_sck) begin
    logic [7:0] t;
    if (spi_cs_n) begin
      sbit = 0;
      t = resp(0);
      spi_miso = t[7];
    end else if (spi_sck && !sck_prev) begin
      if (sbit < 128) seen[sbit/8] = {seen[sbit/8][6:0], spi_mosi};
      sbit++;
    end else if (!spi_sck && sck_prev) begin
      t = resp(sbit / 8);
      spi_miso = t[7 - (sbit % 8)];
    end
    sck_prev = spi_sck;
  end

  // chip-select high time between transactions
  int hi_cnt = 0, min_gap = 1000000;
  logic seen_txn = 1'b0;
  always @(posedge clk) begin
    if (!rst) begin
      if (spi_cs_n) hi_cnt++;
      else begin
        if (hi_cnt > 0 && seen_txn && hi_cnt < min_gap) min_gap = hi_cnt;
        if (hi_cnt > 0) seen_txn = 1'b1;
        hi_cnt = 0;
      end
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic bw(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic br(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [7:0] c;
    c = 8'h01;
    while (c[0]) br(A_CTL, c);
  endtask

  // {opcode, counts, mode, six payload bytes}
  localparam int NV = 7;
  localparam logic [71:0] VECS [NV] = '{
    {8'h9F, 8'h30, 8'h00, 48'h0},
    {8'h03, 8'h43, 8'h00, 48'h112233000000},
    {8'h05, 8'h20, 8'h01, 48'h0},
    {8'h02, 8'h05, 8'h00, 48'hA1B2C3D4E500},
    {8'hAB, 8'h00, 8'h00, 48'h0},
    {8'h0B, 8'h53, 8'h00, 48'h0F1E2D000000},
    {8'h35, 8'h22, 8'h01, 48'hC0DE00000000}
  };

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R10 reset state
    br(A_CTL, d); chk("R10 ctl", d, 8'h00);
    br(A_PTR, d); chk("R10 ptr", d, 8'h00);
    br(A_OPC, d); chk("R10 opc", d, 8'h00);
    br(A_CNT, d); chk("R10 cnt", d, 8'h00);
    chk("R10 cs_n", {7'b0, spi_cs_n}, 8'h01);
    chk("R10 sck", {7'b0, spi_sck}, 8'h00);

    // vector table
    for (int v = 0; v < NV; v++) begin
      logic [7:0] op, cnt, m, e;
      int w, r, rs;
      op = VECS[v][71:64]; cnt = VECS[v][63:56]; m = {5'b0, VECS[v][48], 2'b00};
      w = int'(cnt[3:0]); r = int'(cnt[7:4]);
      rs = (VECS[v][48] && w == 0 && r > 0) ? r - 1 : r;
      bw(A_CTL, m | 8'h02);
      bw(A_OPC, op);
      bw(A_CNT, cnt);
      for (int i = 0; i < w; i++) bw(A_DAT, VECS[v][47 - 8*i -: 8]);
      bw(A_CTL, m | 8'h02);
      bw(A_CTL, m | 8'h01);
      wait_idle();
      br(A_PTR, d); chk(VECS[v][48] ? "R6 end ptr" : "R5 end ptr", d, 8'((w + rs) % 8));
      br(A_CNT, d); chk("R2 counts kept", d, cnt);
      chk("R1 opcode first", seen[0], op);
      for (int i = 0; i < w; i++) chk("R5 payload on wire", seen[1+i], VECS[v][47 - 8*i -: 8]);
      for (int j = 0; j < r; j++) chk("R1 mosi zero in rx", seen[1+w+j], 8'h00);
      bw(A_CTL, m | 8'h02);
      for (int i = 0; i < w + rs; i++) begin
        e = (i < w) ? VECS[v][47 - 8*i -: 8] : resp(1 + i);
        br(A_DAT, d); chk(VECS[v][48] ? "R6 buffer" : "R4 R5 buffer", d, e);
      end
    end

    // R7 pointer reset
    bw(A_CTL, 8'h02);
    for (int i = 0; i < 3; i++) bw(A_DAT, 8'(8'h60 + i));
    br(A_PTR, d); chk("R7 ptr before", d, 8'h03);
    bw(A_CTL, 8'h02);
    br(A_PTR, d); chk("R7 ptr cleared", d, 8'h00);
    br(A_CTL, d); chk("R7 bit reads 0", d & 8'h02, 8'h00);

    // R4 wrap and overwrite
    for (int i = 0; i < 9; i++) bw(A_DAT, 8'(8'h10 + i));
    br(A_PTR, d); chk("R4 wrap ptr", d, 8'h01);
    bw(A_CTL, 8'h02);
    br(A_DAT, d); chk("R4 overwrite", d, 8'h18);
    br(A_DAT, d); chk("R4 next entry", d, 8'h11);

    // R9 writes during busy ignored, R3 busy visible
    bw(A_CTL, 8'h02);
    bw(A_OPC, 8'h66);
    bw(A_CNT, 8'h22);
    bw(A_DAT, 8'h44);
    bw(A_DAT, 8'h55);
    bw(A_CTL, 8'h02);
    bw(A_CTL, 8'h01);
    br(A_CTL, d); chk("R3 busy set", d & 8'h01, 8'h01);
    bw(A_OPC, 8'hEE);
    bw(A_CNT, 8'hFF);
    bw(A_DAT, 8'h77);
    bw(A_CTL, 8'h02);
    br(A_DAT, d); chk("R9 port read busy", d, 8'h00);
    wait_idle();
    br(A_CTL, d); chk("R3 busy cleared", d & 8'h01, 8'h00);
    br(A_OPC, d); chk("R9 opcode kept", d, 8'h66);
    br(A_CNT, d); chk("R9 counts kept", d, 8'h22);
    br(A_PTR, d); chk("R9 ptr", d, 8'h04);
    chk("R9 opcode on wire", seen[0], 8'h66);
    bw(A_CTL, 8'h02);
    br(A_DAT, d); chk("R9 entry0", d, 8'h44);
    br(A_DAT, d); chk("R9 entry1", d, 8'h55);
    br(A_DAT, d); chk("R9 entry2", d, resp(3));
    br(A_DAT, d); chk("R9 entry3", d, resp(4));

    // R8 select gap
    chk("R8 cs_n idle", {7'b0, spi_cs_n}, 8'h01);
    nchk++;
    if (min_gap < SCK_DIV) begin
      nfail++;
      $display("FAIL R8 gap actual %0d expected >= %0d", min_gap, SCK_DIV);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule